// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when the contents of a volatile array are copied into a shadow nonvolatile array (a store) and when the shadow contents are copied back (a recall). A store can be requested by a software command pulse, by an external active-low request line, or by a power-fail comparator. A recall can be requested by a software pulse or happens automatically at power-up and after the supply recovers from a dip. Each transfer is split into two phases. A store erases and then programs. A recall clears and then loads. Each phase is shown to an array model as a level strobe whose length in clock cycles comes from a parameter.

The request line is shared and open-drain. Other agents pull it low to ask for a store. The controller pulls it low while it is working. A "written since last transfer" latch stops pointless stores from the hardware and power-fail sources, and an auto-store enable flag gates the power-fail source. Host reads and writes pass to the array only when the controller is idle and the shared line reads high.

Top module: `nv_xfer_seq`

## Requirements
- R1: During reset `busy_no` is 1 and all four phase strobes are 0. After reset is released, a recall runs at once: `clear_o` is high for CLR_CYC cycles, then `load_o` is high for LOAD_CYC cycles. No host access is granted during this recall.
- R2: A software store pulse received while idle always runs a store, whether or not the write latch is set. `erase_o` is high for ERASE_CYC cycles and is followed directly by `prog_o` for PROG_CYC cycles.
- R3: A store requested through the line or through power-fail runs only if the write latch is set.
- R4: The write latch is set by a host write that is granted (`arr_wr_o` = 1). It is cleared when a store or a recall completes.
- R5: When the line reads low while the controller is idle and the write latch is set, the controller spends HW_DLY_CYC cycles waiting before `erase_o` rises. During the wait `busy_no` is 0 and no host access is granted.
- R6: When the line reads low while idle and the write latch is clear, no phase runs and `busy_no` stays 1. Host access is withheld until the line reads high again.
- R7: After a store completes, host access stays withheld until the line reads high.
- R8: A software recall pulse received while idle runs `clear_o` for CLR_CYC cycles, followed directly by `load_o` for LOAD_CYC cycles.
- R9: A rising `pfail_i` latches a recall request. It also starts a store if auto-store is enabled and the write latch is set. Once `pfail_i` is low again and the controller is idle, the latched recall runs.
- R10: Auto-store is enabled after reset. An `as_dis_i` pulse disables it and an `as_en_i` pulse enables it. Both pulses take effect only while idle.
- R11: A request that arrives while a transfer is running is dropped, not queued. The one exception is the recall latched by a rising `pfail_i`.
- R12: At most one phase strobe is high in any cycle. `busy_no` is 0 exactly while a phase or the hardware wait is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-up) |
| sw_store_i | input | 1 | Software store command pulse |
| sw_recall_i | input | 1 | Software recall command pulse |
| as_dis_i | input | 1 | Auto-store disable command pulse |
| as_en_i | input | 1 | Auto-store enable command pulse |
| pfail_i | input | 1 | Supply below threshold |
| line_ni | input | 1 | Level sensed on the shared request/busy line |
| busy_no | output | 1 | Open-drain pull-down request: 0 drives the line low |
| host_rd_i | input | 1 | Host read request |
| host_wr_i | input | 1 | Host write request |
| arr_rd_o | output | 1 | Granted read toward the array |
| arr_wr_o | output | 1 | Granted write toward the array |
| acc_en_o | output | 1 | Host access currently allowed |
| erase_o | output | 1 | Store erase phase strobe |
| prog_o | output | 1 | Store program phase strobe |
| clear_o | output | 1 | Recall clear phase strobe |
| load_o | output | 1 | Recall load phase strobe |

## Verification
Internal state that has gone wrong shows up at the ports on the first later request that depends on it. If the write latch is wrong, a line or power-fail request either runs an erase that should not happen or skips one that should. If the auto-store flag is wrong, a power-fail edge produces the wrong result. In both cases the error appears within a few cycles of the request. If a phase counter is wrong, the strobe is too long or too short. A fault in the line handshake shows up as `acc_en_o` coming back one cycle too early or not at all.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HWDLY,
    ST_ERASE,
    ST_PROG,
    ST_CLEAR,
    ST_LOAD,
    ST_HOLD,
    ST_BLOCK
  } nvs_state_e;
endpackage

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvs_edge_det.sv
module nvs_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nvs_pkg::*;
#(
  parameter int HW_DLY_CYC = 3,
  parameter int ERASE_CYC  = 4,
  parameter int PROG_CYC   = 5,
  parameter int CLR_CYC    = 2,
  parameter int LOAD_CYC   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic as_dis_i,
  input  logic as_en_i,
  input  logic pfail_i,
  input  logic line_ni,
  output logic busy_no,
  input  logic host_rd_i,
  input  logic host_wr_i,
  output logic arr_rd_o,
  output logic arr_wr_o,
  output logic acc_en_o,
  output logic erase_o,
  output logic prog_o,
  output logic clear_o,
  output logic load_o
);
  localparam int M1   = (HW_DLY_CYC > ERASE_CYC) ? HW_DLY_CYC : ERASE_CYC;
  localparam int M2   = (PROG_CYC > CLR_CYC) ? PROG_CYC : CLR_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXL = (M3 > LOAD_CYC) ? M3 : LOAD_CYC;
  localparam int CW   = $clog2(MAXL + 1);

  nvs_state_e    st_q, st_d;
  logic          wlatch_q, as_en_q, rec_pend_q;
  logic          pf_rise, t_zero, t_load;
  logic [CW-1:0] t_val;

  nvs_edge_det u_pf_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (pfail_i),
    .rise_o(pf_rise)
  );

  // phase length minus one; every state lasts exactly its parameter in cycles
  always_comb begin
    unique case (st_d)
      ST_HWDLY: t_val = CW'(HW_DLY_CYC - 1);
      ST_ERASE: t_val = CW'(ERASE_CYC - 1);
      ST_PROG:  t_val = CW'(PROG_CYC - 1);
      ST_CLEAR: t_val = CW'(CLR_CYC - 1);
      ST_LOAD:  t_val = CW'(LOAD_CYC - 1);
      default:  t_val = '0;
    endcase
  end

  assign t_load = (st_d != st_q);

  nvs_phase_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  // request priority while idle: power-fail store, auto recall, line, sw store, sw recall
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pf_rise && as_en_q && wlatch_q) st_d = ST_ERASE;
        else if (rec_pend_q && !pfail_i)    st_d = ST_CLEAR;
        else if (!line_ni)                  st_d = wlatch_q ? ST_HWDLY : ST_BLOCK;
        else if (sw_store_i)                st_d = ST_ERASE;
        else if (sw_recall_i)               st_d = ST_CLEAR;
      end
      ST_HWDLY: if (t_zero) st_d = ST_ERASE;
      ST_ERASE: if (t_zero) st_d = ST_PROG;
      ST_PROG:  if (t_zero) st_d = ST_HOLD;
      ST_CLEAR: if (t_zero) st_d = ST_LOAD;
      ST_LOAD:  if (t_zero) st_d = ST_IDLE;
      ST_HOLD, ST_BLOCK: if (line_ni) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign acc_en_o = (st_q == ST_IDLE) && line_ni;
  assign arr_rd_o = host_rd_i && acc_en_o;
  assign arr_wr_o = host_wr_i && acc_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wlatch_q   <= 1'b0;
      as_en_q    <= 1'b1;
      rec_pend_q <= 1'b1;  // power-up recall
    end else begin
      st_q <= st_d;
      if (((st_q == ST_PROG) || (st_q == ST_LOAD)) && t_zero) wlatch_q <= 1'b0;
      else if (arr_wr_o)                                       wlatch_q <= 1'b1;
      if (st_q == ST_IDLE) begin
        if (as_dis_i)     as_en_q <= 1'b0;
        else if (as_en_i) as_en_q <= 1'b1;
      end
      if (pf_rise)                                    rec_pend_q <= 1'b1;
      else if (st_q == ST_IDLE && st_d == ST_CLEAR)   rec_pend_q <= 1'b0;
    end
  end

  assign erase_o = (st_q == ST_ERASE);
  assign prog_o  = (st_q == ST_PROG);
  assign clear_o = (st_q == ST_CLEAR);
  assign load_o  = (st_q == ST_LOAD);
  assign busy_no = !(erase_o || prog_o || clear_o || load_o || st_q == ST_HWDLY);

  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, prog_o, clear_o, load_o}));

  a_r2_erase_then_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(erase_o) |-> prog_o);

  a_r8_clear_then_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clear_o) |-> load_o);

  a_r5_busy_blocks_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> !acc_en_o);

  a_r3_line_store_needs_wlatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HWDLY && $past(st_q) == ST_IDLE) |-> $past(wlatch_q));

  a_r4_wlatch_clear_after_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_o) |-> !wlatch_q);
endmodule

// File: tb/nv_xfer_seq_tb.sv
`timescale 1ns/1ps
module nv_xfer_seq_tb;
  localparam int DLY = 3, ER = 4, PR = 5, CL = 2, LD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_store = 0, sw_recall = 0, as_dis = 0, as_en = 0, pfail = 0;
  logic ext_n = 1, host_rd = 0, host_wr = 0;
  logic busy_no, arr_rd, arr_wr, acc_en, erase, prog, clr, load;
  wire  line_n = ext_n & busy_no;

  int n_chk = 0, n_fail = 0;
  int c_er, c_pr, c_cl, c_ld, c_busy, er_at_pr, cl_at_ld, multi;

  always #2.5 clk = ~clk;

  nv_xfer_seq #(.HW_DLY_CYC(DLY), .ERASE_CYC(ER), .PROG_CYC(PR),
                .CLR_CYC(CL), .LOAD_CYC(LD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .as_dis_i(as_dis), .as_en_i(as_en), .pfail_i(pfail), .line_ni(line_n),
    .busy_no(busy_no), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .arr_rd_o(arr_rd), .arr_wr_o(arr_wr), .acc_en_o(acc_en),
    .erase_o(erase), .prog_o(prog), .clear_o(clr), .load_o(load));

  always @(negedge clk) if (rst_n) begin
    if (erase) c_er++;
    if (prog) begin if (c_pr == 0) er_at_pr = c_er; c_pr++; end
    if (clr) c_cl++;
    if (load) begin if (c_ld == 0) cl_at_ld = c_cl; c_ld++; end
    if (!busy_no) c_busy++;
    if (int'(erase) + int'(prog) + int'(clr) + int'(load) > 1) multi++;
  end

  task automatic clr_mon();
    c_er = 0; c_pr = 0; c_cl = 0; c_ld = 0; c_busy = 0;
    er_at_pr = -1; cl_at_ld = -1; multi = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel: 0 sw_store 1 sw_recall 2 as_dis 3 as_en 4 host write
  task automatic pulse(input int sel);
    case (sel)
      0: sw_store = 1; 1: sw_recall = 1; 2: as_dis = 1; 3: as_en = 1;
      default: host_wr = 1;
    endcase
    tick(1);
    sw_store = 0; sw_recall = 0; as_dis = 0; as_en = 0; host_wr = 0;
  endtask

  // {op[1:0], write_first, disable_autostore, expect_store}; op 0 sw, 1 line, 2 pfail
  localparam logic [4:0] VEC [0:6] = '{
    5'b00_0_0_1, 5'b00_1_0_1, 5'b01_0_0_0, 5'b01_1_0_1,
    5'b10_0_0_0, 5'b10_1_0_1, 5'b10_1_1_0};

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_mon();
    tick(2);
    // R1 reset state
    chk("R1 busy in reset", busy_no, 1);
    chk("R1 strobes in reset", int'({erase, prog, clr, load}), 0);
    rst_n = 1;
    host_wr = 1;
    tick(1);
    chk("R1 no write grant in power-up recall", arr_wr, 0);
    host_wr = 0;
    tick(15);
    chk("R1 clear len", c_cl, CL);
    chk("R1 load len", c_ld, LD);
    chk("R1 load follows clear", cl_at_ld, CL);
    chk("R12 busy len recall", c_busy, CL + LD);
    chk("R1 access after recall", acc_en, 1);

    foreach (VEC[k]) begin
      logic [1:0] op;
      op = VEC[k][4:3];
      if (VEC[k][1]) pulse(2);
      if (VEC[k][2]) pulse(4);
      tick(1);
      clr_mon();
      case (op)
        2'd0: begin pulse(0); tick(25); end
        2'd1: begin ext_n = 0; tick(25); ext_n = 1; tick(3); end
        default: begin pfail = 1; tick(25); pfail = 0; tick(15); end
      endcase
      chk($sformatf("R3 R2 R9 R10 vec%0d erase", k), c_er, VEC[k][0] ? ER : 0);
      chk($sformatf("R3 R2 R9 R10 vec%0d prog", k), c_pr, VEC[k][0] ? PR : 0);
      if (op == 2'd2) begin
        chk($sformatf("R9 vec%0d recall after pfail", k), c_ld, LD);
        chk($sformatf("R9 vec%0d recall clear", k), c_cl, CL);
      end
      chk($sformatf("R12 vec%0d busy", k), c_busy,
          (VEC[k][0] ? ER + PR + (op == 2'd1 ? DLY : 0) : 0) + (op == 2'd2 ? CL + LD : 0));
      if (VEC[k][0]) chk($sformatf("R2 vec%0d erase before prog", k), er_at_pr, ER);
      if (VEC[k][1]) pulse(3);
      tick(1);
    end

    // R5 line request with latch set: wait, then erase
    pulse(4);
    clr_mon();
    ext_n = 0;
    tick(1);
    chk("R5 busy during wait", busy_no, 0);
    chk("R5 access off during wait", acc_en, 0);
    host_wr = 1; host_rd = 1;
    tick(1);
    chk("R5 write blocked in wait", arr_wr, 0);
    chk("R5 read blocked in wait", arr_rd, 0);
    host_wr = 0; host_rd = 0;
    tick(DLY - 2);
    chk("R5 no erase before wait ends", erase, 0);
    tick(1);
    chk("R5 erase after wait", erase, 1);
    tick(ER + PR + 4);
    // R7 store done, line still held low externally
    chk("R7 busy released", busy_no, 1);
    chk("R7 access withheld", acc_en, 0);
    ext_n = 1;
    tick(1);
    chk("R7 access back after line high", acc_en, 1);

    // R4 latch cleared by store: line request now blocks only (R6)
    clr_mon();
    ext_n = 0;
    tick(4);
    chk("R6 busy not driven", busy_no, 1);
    chk("R6 access withheld", acc_en, 0);
    chk("R4 R6 no erase", c_er, 0);
    ext_n = 1;
    tick(1);
    chk("R6 access back", acc_en, 1);

    // R11 requests during running store are dropped
    clr_mon();
    pulse(0);
    tick(2);
    pulse(1);
    pulse(0);
    pulse(2);
    tick(25);
    chk("R11 single erase", c_er, ER);
    chk("R11 no recall", c_cl, 0);
    chk("R12 no overlap", multi, 0);
    // R10 as_dis during transfer ignored: pfail store still runs
    pulse(4);
    clr_mon();
    pfail = 1; tick(20); pfail = 0; tick(15);
    chk("R10 disable ignored when busy", c_er, ER);

    // R8 software recall
    clr_mon();
    pulse(1);
    tick(10);
    chk("R8 clear len", c_cl, CL);
    chk("R8 load len", c_ld, LD);
    chk("R8 clear before load", cl_at_ld, CL);
    // R4 recall clears latch: line request gives no store
    pulse(4);
    pulse(1);
    tick(10);
    clr_mon();
    ext_n = 0; tick(5); ext_n = 1; tick(2);
    chk("R4 latch cleared by recall", c_er, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule